// File: doc/BRIEF.md
# Programmable Modulo-N Down Counter

This block is a small synchronous down counter whose count can be replaced from a parallel reload input. A synchronous clear forces the count to zero. An external load request copies the reload value into the count. When neither is active the count steps down by one on each clock edge. A combinational timeout flag marks the all-zero count. The block also drives an active-high seven-segment pattern for the current count.

Setting the auto-reload mode turns the block into a modulo-N counter. In that mode the timeout flag joins the load path, so after reaching zero the count is refilled from the reload input. A reload value of N-1 therefore gives a cycle of N states. The register width is a parameter, with a default of 3 bits.

An asynchronous active-low reset clears the count. The reset is released through an internal synchronizer, so counting starts a few edges after reset is deasserted.

Top module: `modn_down_counter`

## Requirements
- R1: While `rst_n` is low, `count_o` is 0, `tmo_o` is 1 and `seg_o` is 7'h7E. Every register is cleared asynchronously.
- R2: On an edge with `clr_i` high, `count_o` becomes 0. This holds whatever the values of `load_i`, `auto_i` and the current count.
- R3: On an edge with `clr_i` low and `load_i` high, `count_o` takes the value of `reload_i`.
- R4: On an edge with no clear and no load (external or automatic), `count_o` decreases by one. A count of 0 wraps to all ones (7 for the default width).
- R5: `tmo_o` is combinational. It is 1 exactly when `count_o` is 0.
- R6: With `auto_i` high, `tmo_o` acts as a load request, and clear still takes priority. With `reload_i` = 4 the count runs 4,3,2,1,0,4,…, a cycle of five states.
- R7: `seg_o` bit 6 is segment A and bit 0 is segment G, all active high. Counts 0 through 7 give the codes 7E, 30, 6D, 79, 33, 5B, 5F, 70 (hex).
- R8: With `auto_i` high and `reload_i` = 0, a count that reaches 0 stays at 0, and `tmo_o` stays high.
- R9: An external load in the middle of a count takes effect on the next edge. The count then decrements from the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr_i | input | 1 | Synchronous clear; highest priority |
| load_i | input | 1 | External parallel load request |
| auto_i | input | 1 | Auto-reload mode: timeout also requests a load |
| reload_i | input | CNT_W | Value loaded into the count |
| count_o | output | CNT_W | Current count |
| tmo_o | output | 1 | High when the count is zero |
| seg_o | output | 7 | Active-high segments A..G (bit 6 = A) |

## Verification
The checker tests these rules on every cycle:
- the priority of clear over load over decrement, including the automatic load taken from the timeout;
- the value loaded;
- the decrement by one with its wrap from zero;
- the match between the timeout flag and a zero count;
- the hold at zero when the reload value is 0.

Only the bench scenarios show three things: the complete modulo-5 sequence over twelve edges, the segment codes for every count, and the reset-time outputs. They also show that a load arriving mid-count restarts the descent from the new value.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

  localparam int SEG_W = 7;
  localparam int NIB_W = 4;

  typedef logic [SEG_W-1:0] seg_t;

  // Active-high pattern, bit 6 = segment A ... bit 0 = segment G.
  function automatic seg_t hex_to_seg(input logic [NIB_W-1:0] d);
    seg_t s;
    case (d)
      4'h0: s = 7'h7E;
      4'h1: s = 7'h30;
      4'h2: s = 7'h6D;
      4'h3: s = 7'h79;
      4'h4: s = 7'h33;
      4'h5: s = 7'h5B;
      4'h6: s = 7'h5F;
      4'h7: s = 7'h70;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h7B;
      4'hA: s = 7'h77;
      4'hB: s = 7'h1F;
      4'hC: s = 7'h4E;
      4'hD: s = 7'h3D;
      4'hE: s = 7'h4F;
      default: s = 7'h47;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mdc_rst_sync.sv
module mdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= 1'b1;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mdc_next_state.sv
module mdc_next_state #(
  parameter int CNT_W = 3
) (
  input  logic             clr,
  input  logic             ld_ext,
  input  logic             auto_mode,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             at_zero
);

  logic ld_eff;

  always_comb begin
    at_zero = (cnt == '0);
    ld_eff  = ld_ext | (auto_mode & at_zero);
    if (clr) begin
      cnt_nxt = '0;
    end else if (ld_eff) begin
      cnt_nxt = reload;
    end else begin
      cnt_nxt = cnt - 1'b1;
    end
  end

endmodule

// File: rtl/mdc_cnt_reg.sv
module mdc_cnt_reg #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] d,
  output logic [CNT_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/mdc_seg_decode.sv
module mdc_seg_decode #(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0]       value,
  output mdc_pkg::seg_t          seg
);

  import mdc_pkg::*;

  logic [NIB_W-1:0] nib;

  generate
    if (CNT_W >= NIB_W) begin : g_trunc
      assign nib = value[NIB_W-1:0];
    end else begin : g_pad
      assign nib = {{(NIB_W-CNT_W){1'b0}}, value};
    end
  endgenerate

  assign seg = hex_to_seg(nib);

endmodule

// File: rtl/modn_down_counter.sv
module modn_down_counter #(
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             auto_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tmo_o,
  output logic [6:0]       seg_o
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  mdc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mdc_next_state #(.CNT_W(CNT_W)) u_next (
    .clr       (clr_i),
    .ld_ext    (load_i),
    .auto_mode (auto_i),
    .reload    (reload_i),
    .cnt       (cnt_q),
    .cnt_nxt   (cnt_d),
    .at_zero   (tmo_o)
  );

  // The count changes on every edge: clear, load or decrement.
  assign cnt_en = 1'b1;

  mdc_cnt_reg #(.CNT_W(CNT_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (cnt_en),
    .d     (cnt_d),
    .q     (cnt_q)
  );

  mdc_seg_decode #(.CNT_W(CNT_W)) u_seg (
    .value (cnt_q),
    .seg   (seg_o)
  );

  assign count_o = cnt_q;

endmodule

// File: rtl/mdc_checker.sv
module mdc_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             clr_i,
  input logic             load_i,
  input logic             auto_i,
  input logic [CNT_W-1:0] reload_i,
  input logic [CNT_W-1:0] count_o,
  input logic             tmo_o
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= rst_sync_n;
  end

  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_i |=> (count_o == '0));

  // R3
  ext_load_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr_i && load_i) |=> (count_o == $past(reload_i)));

  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr_i && !load_i && !(auto_i && tmo_o))
      |=> (count_o == CNT_W'($past(count_o) - 1'b1)));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!armed)
    (count_o == '0) == tmo_o);

  // R6
  auto_reload_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr_i && auto_i && tmo_o) |=> (count_o == $past(reload_i)));

  // R8
  zero_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr_i && auto_i && tmo_o && reload_i == '0) |=> tmo_o);

endmodule

bind modn_down_counter mdc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .clr_i      (clr_i),
  .load_i     (load_i),
  .auto_i     (auto_i),
  .reload_i   (reload_i),
  .count_o    (count_o),
  .tmo_o      (tmo_o)
);

// File: tb/modn_down_counter_bench.sv
`timescale 1ns/1ps
module modn_down_counter_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr_i, load_i, auto_i;
  logic [2:0] reload_i;
  logic [2:0] count_o;
  logic       tmo_o;
  logic [6:0] seg_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  modn_down_counter u_modn_down_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .load_i   (load_i),
    .auto_i   (auto_i),
    .reload_i (reload_i),
    .count_o  (count_o),
    .tmo_o    (tmo_o),
    .seg_o    (seg_o)
  );

  function automatic logic [6:0] exp_seg(input logic [2:0] v);
    case (v)
      3'd0: return 7'h7E;
      3'd1: return 7'h30;
      3'd2: return 7'h6D;
      3'd3: return 7'h79;
      3'd4: return 7'h33;
      3'd5: return 7'h5B;
      3'd6: return 7'h5F;
      default: return 7'h70;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Check count, timeout and segments together.
  task automatic check_all(input string req, input logic [2:0] exp_cnt);
    check(req, {5'b0, count_o}, {5'b0, exp_cnt});
    check({req, "/R5"}, {7'b0, tmo_o}, {7'b0, exp_cnt == 3'd0});
    check({req, "/R7"}, {1'b0, seg_o}, {1'b0, exp_seg(exp_cnt)});
  endtask

  // Inputs change at the falling edge; one rising edge then passes.
  task automatic step(input logic c, input logic l, input logic a, input logic [2:0] r);
    clr_i = c; load_i = l; auto_i = a; reload_i = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; clr_i = 1'b0; load_i = 1'b0; auto_i = 1'b0; reload_i = 3'd5;
    repeat (3) @(negedge clk);
    check_all("R1", 3'd0);
    clr_i = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1", 3'd0);
  endtask

  task automatic t_clear;
    step(0, 1, 0, 3'd5);
    check_all("R3", 3'd5);
    step(1, 1, 1, 3'd6);
    check_all("R2", 3'd0);
    step(1, 0, 1, 3'd3);
    check_all("R2", 3'd0);
  endtask

  task automatic t_load;
    step(0, 1, 0, 3'd6);
    check_all("R3", 3'd6);
    step(0, 1, 0, 3'd2);
    check_all("R3", 3'd2);
  endtask

  task automatic t_wrap;
    step(1, 0, 0, 3'd0);
    check_all("R2", 3'd0);
    step(0, 0, 0, 3'd3);
    check_all("R4", 3'd7);
    step(0, 0, 0, 3'd3);
    check_all("R4", 3'd6);
    step(0, 0, 0, 3'd3);
    check_all("R4", 3'd5);
  endtask

  task automatic t_mod5;
    logic [2:0] seq [12] = '{3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd4,
                             3'd3, 3'd2, 3'd1, 3'd0, 3'd4, 3'd3};
    step(1, 0, 1, 3'd4);
    check_all("R2", 3'd0);
    for (int i = 0; i < 12; i++) begin
      step(0, 0, 1, 3'd4);
      check_all("R6", seq[i]);
    end
  endtask

  task automatic t_reload_zero;
    step(0, 1, 1, 3'd3);
    check_all("R3", 3'd3);
    step(0, 0, 1, 3'd0);
    check_all("R8", 3'd2);
    step(0, 0, 1, 3'd0);
    check_all("R8", 3'd1);
    step(0, 0, 1, 3'd0);
    check_all("R8", 3'd0);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 1, 3'd0);
      check_all("R8", 3'd0);
    end
  endtask

  task automatic t_midload;
    step(0, 1, 1, 3'd4);
    check_all("R9", 3'd4);
    step(0, 0, 1, 3'd4);
    check_all("R9", 3'd3);
    step(0, 1, 1, 3'd6);
    check_all("R9", 3'd6);
    step(0, 0, 1, 3'd6);
    check_all("R9", 3'd5);
    step(0, 0, 1, 3'd6);
    check_all("R9", 3'd4);
  endtask

  task automatic t_seg;
    for (int v = 0; v < 8; v++) begin
      step(0, 1, 0, 3'(v));
      check_all("R7", 3'(v));
    end
  endtask

  initial begin
    t_reset();
    t_clear();
    t_load();
    t_wrap();
    t_mod5();
    t_reload_zero();
    t_midload();
    t_seg();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule